// File: doc/BRIEF.md
# Multi-Channel DMA Control/Status Register Bank

This block holds the software-visible control and status state of a 64-channel DMA engine. It sits on a plain 32-bit register bus with a single-cycle write strobe and combinational read data. Each 64-bit channel set is reached as two 32-bit words, one for channels 31..0 and one for channels 63..32. Those sets are the request-enable mask, the error-interrupt-enable mask, the completion flags and the error flags.

Software can rewrite a whole mask word in one write. It can also change a single channel's enable bit by writing that channel's number to a command register. A start command emits a one-cycle start pulse to the chosen channel.

The channels report completion and failure through per-channel event inputs. Events raise sticky flags that software clears by writing ones. The details of the first failure are frozen in a status word until every error flag has been cleared. A single interrupt line combines all pending completions with the failures whose interrupt is enabled.

Top module: `chan_ctl_regs`

## Requirements
- R1: After reset every readable register reads zero, and `irq_o`, `start_o` and `req_en_o` are zero.
- R2: Control register (word 0) bit 31 drives `clk_gate_en_o`, bit 3 drives `rr_group_o` and bit 2 drives `rr_chan_o`. Its other bits read zero.
- R3: Request-enable words: word 2 holds channels 63..32 and word 3 holds channels 31..0. Both are read/write and drive `req_en_o`. Writing a channel number in `wdata_i[7:0]` to word 6 sets that channel's bit, and writing it to word 7 clears the bit.
- R4: Error-interrupt-enable words: word 4 holds channels 63..32 and word 5 holds channels 31..0. Both are read/write. Writing a channel number to word 8 sets that channel's bit, and writing it to word 9 clears the bit.
- R5: Writing a channel number to word 10 raises that channel's bit of `start_o` for exactly the one cycle after the write.
- R6: A command write (words 6 to 10) whose byte has bit 6 or bit 7 set changes nothing.
- R7: A `done_evt_i` bit sets the matching completion flag. The flags are read from word 11 (channels 63..32) and word 12 (channels 31..0). Writing ones to a flag word clears those flags. An event in the same cycle as the clear leaves its flag set.
- R8: An `err_evt_i` bit sets the matching error flag. The flags are read from word 13 (channels 63..32) and word 14 (channels 31..0). They clear by writing ones, and an event in the same cycle as the clear leaves its flag set.
- R9: When the status word (word 1) is not valid and any error event occurs, the status word loads the following fields. Bit 31 is set as the valid bit. Bits 13:8 get the lowest-numbered failing channel. Bits 15:14 get `err_info_i[9:8]` (group priority fault, channel priority fault). Bits 7:0 get `err_info_i[7:0]`, whose bits from 7 down to 0 mean source address, source offset, destination address, destination offset, count configuration, chaining configuration, source bus and destination bus faults.
- R10: While the status word is valid, further error events only set error flags and leave the status word unchanged.
- R11: The status word returns to zero in the same cycle that the last error flag is cleared.
- R12: `irq_o` is high exactly when any completion flag is set, or any error flag whose error-interrupt-enable bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Word index of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| done_evt_i | input | 64 | Per-channel completion events |
| err_evt_i | input | 64 | Per-channel error events |
| err_info_i | input | 10 | Fault details that accompany an error event |
| req_en_o | output | 64 | Request-enable mask |
| start_o | output | 64 | One-cycle start pulses |
| clk_gate_en_o | output | 1 | Dynamic clock gating enable |
| rr_group_o | output | 1 | Round-robin group arbitration select |
| rr_chan_o | output | 1 | Round-robin channel arbitration select |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The collision that matters is a channel event arriving in the same cycle as a software write-one-to-clear of that channel's flag. The bench drives a completion event together with a clear of the same bit, and later an error event together with a clear of the same error word. It then reads the flag word back and expects the bit still set. For the error case it also expects the status word to have captured that channel, because the event made the flag set non-empty in the very cycle of the clear.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;
  localparam int unsigned CH_FIELD_W = 6;
  localparam int unsigned INFO_W     = 10;

  typedef enum logic [3:0] {
    A_CTRL    = 4'd0,
    A_ESTAT   = 4'd1,
    A_REQ_HI  = 4'd2,
    A_REQ_LO  = 4'd3,
    A_EEI_HI  = 4'd4,
    A_EEI_LO  = 4'd5,
    A_SET_REQ = 4'd6,
    A_CLR_REQ = 4'd7,
    A_SET_EEI = 4'd8,
    A_CLR_EEI = 4'd9,
    A_START   = 4'd10,
    A_IRQF_HI = 4'd11,
    A_IRQF_LO = 4'd12,
    A_ERRF_HI = 4'd13,
    A_ERRF_LO = 4'd14
  } reg_addr_e;

  typedef struct packed {
    logic                  vld;
    logic [14:0]           zero;
    logic                  grp_fault;
    logic                  chn_fault;
    logic [CH_FIELD_W-1:0] chan;
    logic [7:0]            detail;
  } estat_t;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode #(
  parameter int unsigned NUM_CH = 64
) (
  input  logic              valid_i,
  input  logic [7:0]        byte_i,
  output logic [NUM_CH-1:0] sel_o
);
  localparam int unsigned CH_W = $clog2(NUM_CH);

  logic in_range;
  assign in_range = (byte_i[7:CH_W] == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign sel_o[i] = valid_i && in_range && (byte_i[CH_W-1:0] == CH_W'(i));
  end
endmodule

// File: rtl/mask_reg.sv
module mask_reg #(
  parameter int unsigned NUM_CH = 64,
  parameter int unsigned DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [NUM_CH-1:0] mask_o
);
  logic [NUM_CH-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = (mask_q | set_i) & ~clr_i;
    if (wr_lo_i) mask_d[DW-1:0] = wdata_i;
    if (wr_hi_i) mask_d[NUM_CH-1:DW] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // set command lands in the mask (R3 for requests, R4 for error enables)
  p_cmd_set_r3_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((mask_q & $past(set_i)) == $past(set_i)));
  p_cmd_clr_r3_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((mask_q & $past(clr_i)) == '0));
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int unsigned NUM_CH = 64,
  parameter int unsigned DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic              clr_hi_i,
  input  logic              clr_lo_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [NUM_CH-1:0] flags_o,
  output logic [NUM_CH-1:0] flags_d_o
);
  logic [NUM_CH-1:0] flags_q, flags_d, clr;

  assign clr     = {clr_hi_i ? wdata_i : DW'(0), clr_lo_i ? wdata_i : DW'(0)};
  assign flags_d = (flags_q & ~clr) | evt_i;  // event beats clear

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o   = flags_q;
  assign flags_d_o = flags_d;

  p_evt_wins_r7_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));
  p_flag_sticky_r7_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_hi_i && !clr_lo_i) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/err_capture.sv
module err_capture
  import dmacsr_pkg::*;
#(
  parameter int unsigned NUM_CH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] err_evt_i,
  input  logic [INFO_W-1:0] info_i,
  input  logic [NUM_CH-1:0] errf_d_i,
  output estat_t            estat_o
);
  localparam int unsigned CH_W = $clog2(NUM_CH);

  estat_t          estat_q, estat_d;
  logic [CH_W-1:0] first_ch;

  always_comb begin
    first_ch = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (err_evt_i[i]) first_ch = CH_W'(i);
    end
  end

  always_comb begin
    estat_d = estat_q;
    if (errf_d_i == '0) begin
      estat_d = '0;
    end else if (!estat_q.vld && (|err_evt_i)) begin
      estat_d           = '0;
      estat_d.vld       = 1'b1;
      estat_d.grp_fault = info_i[9];
      estat_d.chn_fault = info_i[8];
      estat_d.chan      = CH_FIELD_W'(first_ch);
      estat_d.detail    = info_i[7:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) estat_q <= '0;
    else         estat_q <= estat_d;
  end

  assign estat_o = estat_q;

  p_capture_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!estat_q.vld && (|err_evt_i)) |=> estat_q.vld);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (estat_q.vld && (|errf_d_i)) |=> $stable(estat_q));
  p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (errf_d_i == '0) |=> (estat_q == '0));
endmodule

// File: rtl/chan_ctl_regs.sv
module chan_ctl_regs
  import dmacsr_pkg::*;
#(
  parameter int unsigned NUM_CH = 64,
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NUM_CH-1:0] done_evt_i,
  input  logic [NUM_CH-1:0] err_evt_i,
  input  logic [INFO_W-1:0] err_info_i,
  output logic [NUM_CH-1:0] req_en_o,
  output logic [NUM_CH-1:0] start_o,
  output logic              clk_gate_en_o,
  output logic              rr_group_o,
  output logic              rr_chan_o,
  output logic              irq_o
);
  localparam int unsigned CH_W = $clog2(NUM_CH);
  localparam int unsigned NCMD = 5;  // set/clr req, set/clr eei, start

  logic [NCMD-1:0]              cmd_hit;
  logic [NCMD-1:0][NUM_CH-1:0]  cmd_sel;
  logic [2:0]                   ctrl_q;
  logic [NUM_CH-1:0]            start_q, eei, irqf, irqf_d, errf, errf_d;
  estat_t                       estat;

  function automatic logic wr_at(input reg_addr_e a);
    return wr_en_i && (addr_i == AW'(a));
  endfunction

  for (genvar k = 0; k < NCMD; k++) begin : g_cmd
    assign cmd_hit[k] = wr_en_i && (addr_i == AW'(A_SET_REQ) + AW'(k));
    cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
      .valid_i(cmd_hit[k]),
      .byte_i (wdata_i[7:0]),
      .sel_o  (cmd_sel[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      start_q <= '0;
    end else begin
      if (wr_at(A_CTRL)) ctrl_q <= {wdata_i[31], wdata_i[3], wdata_i[2]};
      start_q <= cmd_sel[4];
    end
  end

  mask_reg #(.NUM_CH(NUM_CH), .DW(DW)) u_req (
    .clk_i, .rst_ni,
    .set_i  (cmd_sel[0]),
    .clr_i  (cmd_sel[1]),
    .wr_hi_i(wr_at(A_REQ_HI)),
    .wr_lo_i(wr_at(A_REQ_LO)),
    .wdata_i,
    .mask_o (req_en_o)
  );

  mask_reg #(.NUM_CH(NUM_CH), .DW(DW)) u_eei (
    .clk_i, .rst_ni,
    .set_i  (cmd_sel[2]),
    .clr_i  (cmd_sel[3]),
    .wr_hi_i(wr_at(A_EEI_HI)),
    .wr_lo_i(wr_at(A_EEI_LO)),
    .wdata_i,
    .mask_o (eei)
  );

  flag_bank #(.NUM_CH(NUM_CH), .DW(DW)) u_irqf (
    .clk_i, .rst_ni,
    .evt_i    (done_evt_i),
    .clr_hi_i (wr_at(A_IRQF_HI)),
    .clr_lo_i (wr_at(A_IRQF_LO)),
    .wdata_i,
    .flags_o  (irqf),
    .flags_d_o(irqf_d)
  );

  flag_bank #(.NUM_CH(NUM_CH), .DW(DW)) u_errf (
    .clk_i, .rst_ni,
    .evt_i    (err_evt_i),
    .clr_hi_i (wr_at(A_ERRF_HI)),
    .clr_lo_i (wr_at(A_ERRF_LO)),
    .wdata_i,
    .flags_o  (errf),
    .flags_d_o(errf_d)
  );

  err_capture #(.NUM_CH(NUM_CH)) u_cap (
    .clk_i, .rst_ni,
    .err_evt_i,
    .info_i  (err_info_i),
    .errf_d_i(errf_d),
    .estat_o (estat)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(A_CTRL): begin
        rdata_o[31] = ctrl_q[2];
        rdata_o[3]  = ctrl_q[1];
        rdata_o[2]  = ctrl_q[0];
      end
      AW'(A_ESTAT):   rdata_o = estat;
      AW'(A_REQ_HI):  rdata_o = req_en_o[NUM_CH-1:DW];
      AW'(A_REQ_LO):  rdata_o = req_en_o[DW-1:0];
      AW'(A_EEI_HI):  rdata_o = eei[NUM_CH-1:DW];
      AW'(A_EEI_LO):  rdata_o = eei[DW-1:0];
      AW'(A_IRQF_HI): rdata_o = irqf[NUM_CH-1:DW];
      AW'(A_IRQF_LO): rdata_o = irqf[DW-1:0];
      AW'(A_ERRF_HI): rdata_o = errf[NUM_CH-1:DW];
      AW'(A_ERRF_LO): rdata_o = errf[DW-1:0];
      default:        rdata_o = '0;
    endcase
  end

  assign start_o       = start_q;
  assign clk_gate_en_o = ctrl_q[2];
  assign rr_group_o    = ctrl_q[1];
  assign rr_chan_o     = ctrl_q[0];
  assign irq_o         = (|irqf) || (|(errf & eei));

  p_ctrl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_at(A_CTRL) |=> (clk_gate_en_o == $past(wdata_i[31]) && rr_chan_o == $past(wdata_i[2])));
  p_start_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_hit[4] && wdata_i[7:CH_W] == '0) |=> start_o[$past(wdata_i[CH_W-1:0])]);
  p_start_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_hit[4] |=> (start_o == '0));
  p_bad_cmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_hit[4] && wdata_i[7:CH_W] != '0) |=> (start_o == '0));
  p_irq_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_evt_i) |=> irq_o);
endmodule

// File: tb/chan_ctl_regs_tb.sv
module chan_ctl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] done_evt = '0, err_evt = '0;
  logic [9:0]  err_info = '0;
  logic [63:0] req_en, start;
  logic        gate, rr_grp, rr_ch, irq;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  chan_ctl_regs dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_evt_i(done_evt),
    .err_evt_i(err_evt), .err_info_i(err_info), .req_en_o(req_en),
    .start_o(start), .clk_gate_en_o(gate), .rr_group_o(rr_grp),
    .rr_chan_o(rr_ch), .irq_o(irq)
  );

  // {write addr, write data, read addr, expected read}
  localparam logic [71:0] VEC [0:11] = '{
    {4'd6, 32'd5,          4'd3, 32'h0000_0020},  // R3 set ch5
    {4'd6, 32'd40,         4'd2, 32'h0000_0100},  // R3 set ch40
    {4'd6, 32'h45,         4'd3, 32'h0000_0020},  // R6 bit6 ignored
    {4'd7, 32'd5,          4'd3, 32'h0000_0000},  // R3 clear ch5
    {4'd8, 32'd63,         4'd4, 32'h8000_0000},  // R4 set ch63
    {4'd8, 32'h81,         4'd5, 32'h0000_0000},  // R6 bit7 ignored
    {4'd8, 32'd0,          4'd5, 32'h0000_0001},  // R4 set ch0
    {4'd9, 32'd63,         4'd4, 32'h0000_0000},  // R4 clear ch63
    {4'd0, 32'hFFFF_FFFF,  4'd0, 32'h8000_000C},  // R2 only defined bits
    {4'd2, 32'h1234_5678,  4'd2, 32'h1234_5678},  // R3 full word
    {4'd7, 32'd35,         4'd2, 32'h1234_5670},  // R3 clear ch35
    {4'd2, 32'h0,          4'd2, 32'h0000_0000}   // R3 full word clear
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    check(rdata === exp, req, 64'(rdata), 64'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 15; a++) rd_chk(4'(a), 32'h0, "R1 reset readback");
    check(irq === 1'b0 && start === '0 && req_en === '0, "R1 outputs", {start[62:0], irq}, 64'h0);

    // table walk
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][71:68], VEC[i][67:36]);
      rd_chk(VEC[i][35:32], VEC[i][31:0], $sformatf("R3/R4/R6/R2 vector %0d", i));
    end
    check(gate && rr_grp && rr_ch, "R2 control outputs", {61'h0, gate, rr_grp, rr_ch}, 64'h7);

    // R5 start pulse
    wr(4'd10, 32'd17);
    check(start === (64'd1 << 17), "R5 start pulse", start, 64'd1 << 17);
    @(negedge clk);
    check(start === '0, "R5 pulse one cycle", start, 64'h0);
    // R6 start with bit 6 set
    wr(4'd10, 32'h51);
    check(start === '0, "R6 bad start ignored", start, 64'h0);

    // R7 completion flags
    @(negedge clk);
    done_evt = (64'd1 << 3) | (64'd1 << 50);
    @(negedge clk);
    done_evt = '0;
    rd_chk(4'd12, 32'h8, "R7 flag lo");
    rd_chk(4'd11, 32'h0004_0000, "R7 flag hi");
    check(irq === 1'b1, "R12 irq on done", 64'(irq), 64'h1);
    wr(4'd12, 32'h8);
    rd_chk(4'd12, 32'h0, "R7 w1c lo");
    check(irq === 1'b1, "R12 irq hi still set", 64'(irq), 64'h1);
    wr(4'd11, 32'hFFFF_FFFF);
    rd_chk(4'd11, 32'h0, "R7 w1c all");
    check(irq === 1'b0, "R12 irq cleared", 64'(irq), 64'h0);
    // R7 event and clear collide
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd12; wdata = 32'h4; done_evt = 64'd1 << 2;
    @(negedge clk);
    wr_en = 1'b0; done_evt = '0;
    rd_chk(4'd12, 32'h4, "R7 event beats clear");
    wr(4'd12, 32'h4);
    rd_chk(4'd12, 32'h0, "R7 cleared after collide");

    // R9 first error capture
    @(negedge clk);
    err_evt = (64'd1 << 10) | (64'd1 << 45); err_info = 10'h3A5;
    @(negedge clk);
    err_evt = '0; err_info = '0;
    rd_chk(4'd1, 32'h8000_CAA5, "R9 status capture");
    rd_chk(4'd14, 32'h0000_0400, "R8 err flag lo");
    rd_chk(4'd13, 32'h0000_2000, "R8 err flag hi");
    check(irq === 1'b0, "R12 masked errors", 64'(irq), 64'h0);
    wr(4'd8, 32'd45);
    check(irq === 1'b1, "R12 enabled error", 64'(irq), 64'h1);

    // R10 later error does not overwrite
    @(negedge clk);
    err_evt = 64'd1 << 2; err_info = 10'h001;
    @(negedge clk);
    err_evt = '0; err_info = '0;
    rd_chk(4'd1, 32'h8000_CAA5, "R10 status held");
    rd_chk(4'd14, 32'h0000_0404, "R10 flag still set");

    // R11 release on last clear
    wr(4'd14, 32'hFFFF_FFFF);
    rd_chk(4'd1, 32'h8000_CAA5, "R11 held while hi flag set");
    wr(4'd13, 32'h0000_2000);
    rd_chk(4'd1, 32'h0, "R11 status cleared");
    check(irq === 1'b0, "R12 irq after error clear", 64'(irq), 64'h0);

    // R8 error and clear collide: flag stays, status captures ch7
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd14; wdata = 32'h80; err_evt = 64'd1 << 7;
    @(negedge clk);
    wr_en = 1'b0; err_evt = '0;
    rd_chk(4'd14, 32'h80, "R8 event beats clear");
    rd_chk(4'd1, 32'h8000_0700, "R9 capture during clear");
    wr(4'd14, 32'h80);
    rd_chk(4'd1, 32'h0, "R11 cleared again");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule